// File: doc/BRIEF.md
# Clock Request Output Gating Controller

This block decides, for each of a set of differential clock outputs, whether the output drivers run or sit parked with both legs released. Three active-low request lines come in from the board with no timing relation to the reference clock. Each line is resynchronised and must hold a new level on two consecutive samples before it counts. That filters out short spikes and bounce.

Every output has a mask row that names the request lines allowed to stop it. A stop never cuts a high phase short. The output keeps passing its own free-running clock until the true leg has gone low, and only then drops its enable. When an accepted request is withdrawn, a shared restart timer runs for two output clock periods. All outputs that are stopped and no longer held by any mapped request then come back on the same reference edge, starting from a low true leg.

Top module: `clkreq_gate`

## Requirements
- R1: There are `N_REQ` (default 3) request pins `req_n`. Each is active low, so 0 means stop requested. Bit j is line j.
- R2: A pin level is accepted only after a two-flop synchronizer and two equal consecutive synchronised samples. A level driven just before reference edge 1 and held becomes effective after edge 4. A pin pulse lasting one reference cycle has no effect on any output.
- R3: Bit `i*N_REQ+j` of `stop_mask` set to 1 lets line j stop output i. An accepted request on line j leaves every output whose bit for j is 0 running.
- R4: A stop takes effect only at a reference edge where the output's true leg was already driven low. While the leg is high, the output keeps following its source clock.
- R5: A stopped output drives `drv_en`=0, `drv_t`=0 and `drv_c`=0. A running output drives `drv_en`=1 and `drv_c` = NOT `drv_t`.
- R6: An accepted release loads a timer of `RESTART_PERIODS*PERIOD_REF` (default 2*4 = 8) reference cycles. With defaults, a release driven before edge 1 re-enables outputs after edge 12. Every stopped output without an active mapped request re-enables on that same edge, with its true leg low.
- R7: An output mapped to several lines stays stopped while any of its mapped lines is still requested.
- R8: Reset parks nothing. All `drv_en` are 1, all `drv_t` are 0, all `drv_c` are 1, and every line is treated as released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n | input | N_REQ | Asynchronous active-low stop requests |
| stop_mask | input | N_OUT*N_REQ | Per-output stoppable mask, row i at bits i*N_REQ and up |
| out_clk | input | N_OUT | Free-running source clock of each output, sampled on clk_ref |
| drv_t | output | N_OUT | True leg drive level |
| drv_c | output | N_OUT | Complement leg drive level |
| drv_en | output | N_OUT | Driver enable; 0 releases both legs |

## Verification
A corrupted filter state shows at the ports within a few reference cycles as one of two faults: an enable that drops after a single-cycle spike, or a stop that lands one edge early or late. A wrong restart count makes `drv_en` rise away from edge 12 after the release. A lane stuck in the wrong state shows up as an enable that falls while its true leg is high, or as two outputs released together that come back on different edges. The reference model compares all three output vectors on every cycle, so any such divergence is reported in the cycle it appears.

// File: rtl/clkreq_pkg.sv
package clkreq_pkg;
    typedef struct packed {
        logic en;
        logic lvl;
    } lane_st_t;
endpackage

// File: rtl/clkreq_filter.sv
module clkreq_filter #(
    parameter int N_REQ = 3
) (
    input  logic             clk_ref,
    input  logic             rst_n,
    input  logic [N_REQ-1:0] req_n,
    output logic [N_REQ-1:0] acc_q,
    output logic             rel_ev
);
    typedef struct packed {
        logic [N_REQ-1:0] s1;
        logic [N_REQ-1:0] s2;
        logic [N_REQ-1:0] prv;
        logic [N_REQ-1:0] acc;
    } flt_st_t;

    flt_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.s1  = req_n;
        st_d.s2  = st_q.s1;
        st_d.prv = st_q.s2;
        for (int j = 0; j < N_REQ; j++) begin
            if (st_q.s2[j] == st_q.prv[j]) begin
                st_d.acc[j] = st_q.s2[j];
            end
        end
    end

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{s1: '1, s2: '1, prv: '1, acc: '1};
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_q  = st_q.acc;
    assign rel_ev = |(st_d.acc & ~st_q.acc);
endmodule

// File: rtl/clkreq_restart_tmr.sv
module clkreq_restart_tmr #(
    parameter int RESTART_CYC = 8
) (
    input  logic clk_ref,
    input  logic rst_n,
    input  logic load,
    output logic wake
);
    localparam int CW = $clog2(RESTART_CYC + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.cnt = CW'(RESTART_CYC);
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign wake = (st_q.cnt == CW'(1));
endmodule

// File: rtl/clkreq_lane.sv
module clkreq_lane
    import clkreq_pkg::*;
(
    input  logic clk_ref,
    input  logic rst_n,
    input  logic src_clk,
    input  logic stop,
    input  logic wake,
    output logic leg_t,
    output logic leg_c,
    output logic leg_en
);
    lane_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.en) begin
            if (stop && !st_q.lvl) begin
                st_d.en  = 1'b0;
                st_d.lvl = 1'b0;
            end else begin
                st_d.lvl = src_clk;
            end
        end else begin
            st_d.lvl = 1'b0;
            if (wake && !stop) begin
                st_d.en = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{en: 1'b1, lvl: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign leg_t  = st_q.lvl;
    assign leg_c  = st_q.en & ~st_q.lvl;
    assign leg_en = st_q.en;
endmodule

// File: rtl/clkreq_gate.sv
module clkreq_gate #(
    parameter int N_OUT           = 4,
    parameter int N_REQ           = 3,
    parameter int PERIOD_REF      = 4,
    parameter int RESTART_PERIODS = 2
) (
    input  logic                   clk_ref,
    input  logic                   rst_n,
    input  logic [N_REQ-1:0]       req_n,
    input  logic [N_OUT*N_REQ-1:0] stop_mask,
    input  logic [N_OUT-1:0]       out_clk,
    output logic [N_OUT-1:0]       drv_t,
    output logic [N_OUT-1:0]       drv_c,
    output logic [N_OUT-1:0]       drv_en
);
    localparam int RESTART_CYC = RESTART_PERIODS * PERIOD_REF;

    logic [N_REQ-1:0] acc_n;
    logic             rel_ev;
    logic             wake;

    clkreq_filter #(.N_REQ(N_REQ)) u_flt (
        .clk_ref (clk_ref),
        .rst_n   (rst_n),
        .req_n   (req_n),
        .acc_q   (acc_n),
        .rel_ev  (rel_ev)
    );

    clkreq_restart_tmr #(.RESTART_CYC(RESTART_CYC)) u_tmr (
        .clk_ref (clk_ref),
        .rst_n   (rst_n),
        .load    (rel_ev),
        .wake    (wake)
    );

    for (genvar i = 0; i < N_OUT; i++) begin : g_lane
        logic hold;
        assign hold = |(stop_mask[i*N_REQ +: N_REQ] & ~acc_n);

        clkreq_lane u_lane (
            .clk_ref (clk_ref),
            .rst_n   (rst_n),
            .src_clk (out_clk[i]),
            .stop    (hold),
            .wake    (wake),
            .leg_t   (drv_t[i]),
            .leg_c   (drv_c[i]),
            .leg_en  (drv_en[i])
        );
    end
endmodule

// File: rtl/clkreq_gate_chk.sv
module clkreq_gate_chk #(
    parameter int N_OUT = 4,
    parameter int N_REQ = 3
) (
    input logic                   clk_ref,
    input logic                   rst_n,
    input logic [N_OUT*N_REQ-1:0] stop_mask,
    input logic [N_OUT-1:0]       drv_t,
    input logic [N_OUT-1:0]       drv_c,
    input logic [N_OUT-1:0]       drv_en,
    input logic                   wake
);
    a_r5_parked_legs: assert property (@(posedge clk_ref) disable iff (!rst_n)
        ((~drv_en & (drv_t | drv_c)) == '0));

    a_r5_running_diff: assert property (@(posedge clk_ref) disable iff (!rst_n)
        ((drv_en & ~(drv_t ^ drv_c)) == '0));

    for (genvar i = 0; i < N_OUT; i++) begin : g_chk
        a_r4_halt_low: assert property (@(posedge clk_ref) disable iff (!rst_n)
            $fell(drv_en[i]) |-> !$past(drv_t[i]));

        a_r6_wake_restart: assert property (@(posedge clk_ref) disable iff (!rst_n)
            $rose(drv_en[i]) |-> ($past(wake) && !drv_t[i]));

        a_r3_free_lane: assert property (@(posedge clk_ref) disable iff (!rst_n)
            ($past(stop_mask[i*N_REQ +: N_REQ] == '0) && $past(drv_en[i])) |-> drv_en[i]);
    end
endmodule

bind clkreq_gate clkreq_gate_chk #(.N_OUT(N_OUT), .N_REQ(N_REQ)) u_chk (
    .clk_ref   (clk_ref),
    .rst_n     (rst_n),
    .stop_mask (stop_mask),
    .drv_t     (drv_t),
    .drv_c     (drv_c),
    .drv_en    (drv_en),
    .wake      (wake)
);

// File: tb/sim_clkreq_gate.sv
`timescale 1ns/1ps
module sim_clkreq_gate;
    localparam int NO = 4;
    localparam int NR = 3;
    localparam int RC = 8;

    logic            clk_ref = 1'b0;
    logic            rst_n   = 1'b0;
    logic [NR-1:0]   req_n   = '1;
    logic [NO*NR-1:0] stop_mask;
    logic [NO-1:0]   out_clk = '0;
    logic [NO-1:0]   drv_t, drv_c, drv_en;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #10 clk_ref = ~clk_ref;

    clkreq_gate u0 (
        .clk_ref(clk_ref), .rst_n(rst_n), .req_n(req_n), .stop_mask(stop_mask),
        .out_clk(out_clk), .drv_t(drv_t), .drv_c(drv_c), .drv_en(drv_en)
    );

    // masks: out0 <- line0; out1 <- lines 0,1; out2 <- none; out3 <- lines 1,2
    initial stop_mask = 12'b110_000_011_001;

    // free-running source clocks, output i has half period i+2 cycles
    int ph [NO];
    initial for (int i = 0; i < NO; i++) ph[i] = 0;
    always @(negedge clk_ref) begin
        for (int i = 0; i < NO; i++) begin
            if (ph[i] == i + 1) begin
                ph[i] = 0;
                out_clk[i] = ~out_clk[i];
            end else begin
                ph[i] = ph[i] + 1;
            end
        end
    end

    // behavioural reference model
    logic [NR-1:0] hist [$];
    logic [NR-1:0] m_acc;
    logic [NO-1:0] m_en, m_t;
    int            m_cnt;

    always @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) begin
            hist  = '{'1, '1, '1, '1};
            m_acc = '1;
            m_en  = '1;
            m_t   = '0;
            m_cnt = 0;
        end else begin
            logic [NR-1:0] nacc;
            bit wk;
            hist.push_front(req_n);
            void'(hist.pop_back());
            nacc = m_acc;
            for (int j = 0; j < NR; j++)
                if (hist[2][j] == hist[3][j]) nacc[j] = hist[2][j];
            wk = (m_cnt == 1);
            for (int i = 0; i < NO; i++) begin
                bit held;
                held = |(stop_mask[i*NR +: NR] & ~m_acc);
                if (m_en[i]) begin
                    if (held && !m_t[i]) begin m_en[i] = 0; m_t[i] = 0; end
                    else m_t[i] = out_clk[i];
                end else begin
                    m_t[i] = 0;
                    if (wk && !held) m_en[i] = 1;
                end
            end
            if (|(nacc & ~m_acc)) m_cnt = RC;
            else if (m_cnt > 0) m_cnt = m_cnt - 1;
            m_acc = nacc;
        end
    end

    task automatic chk(input string tag, input logic [NO-1:0] act, input logic [NO-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk_ref) begin
        if (rst_n && !done) begin
            chk("R4 R6 enable vs model", drv_en, m_en);
            chk("R5 true leg vs model", drv_t, m_t);
            chk("R5 complement leg vs model", drv_c, m_en & ~m_t);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk_ref);
    endtask

    initial begin
        int n;
        cyc(4);
        chk("R8 reset enables", drv_en, '1);
        chk("R8 reset true legs", drv_t, '0);
        chk("R1 R8 reset complement legs", drv_c, '1);
        rst_n = 1'b1;
        cyc(10);

        // R2: one-cycle spike is ignored
        req_n[0] = 1'b0; cyc(1); req_n[0] = 1'b1;
        cyc(20);
        chk("R2 spike ignored", drv_en, '1);

        // R3: line 0 stops only its mapped outputs
        req_n[0] = 1'b0;
        cyc(20);
        chk("R3 mapped outputs stopped", drv_en, 4'b1100);
        chk("R5 parked legs low", drv_t & ~drv_en, '0);

        // R6: release latency and simultaneous restart
        req_n[0] = 1'b1;
        n = 0;
        do begin cyc(1); n++; end while (!drv_en[0] && n < 100);
        total++;
        if (n != 4 + RC) begin
            bad++;
            $display("FAIL R6 restart latency actual=%0d expected=%0d", n, 4 + RC);
        end
        chk("R6 restart together", drv_en, '1);
        cyc(10);

        // R7: multi-mapped output held by remaining line
        req_n[1] = 1'b0; req_n[2] = 1'b0;
        cyc(25);
        chk("R7 both lines stop out1 out3", drv_en, 4'b0101);
        req_n[1] = 1'b1;
        cyc(30);
        chk("R7 out3 still held by line2", drv_en, 4'b0111);
        req_n[2] = 1'b1;
        cyc(30);
        chk("R7 out3 released", drv_en, '1);

        // R2: two-cycle request is accepted, model tracks it
        req_n[0] = 1'b0; cyc(2); req_n[0] = 1'b1;
        cyc(40);
        chk("R2 short accepted request recovered", drv_en, '1);

        // R8: reset while a request is held
        req_n[0] = 1'b0;
        cyc(25);
        rst_n = 1'b0;
        cyc(2);
        chk("R8 reset clears stops", drv_en, '1);
        rst_n = 1'b1;
        cyc(25);
        chk("R3 re-stopped after reset", drv_en, 4'b1100);
        req_n[0] = 1'b1;
        cyc(30);
        chk("R6 final restart", drv_en, '1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule